// File: doc/BRIEF.md
# Byte-Wide Stack Engine with Subroutine Call and Return

This block runs the stack side of a small 8-bit processor with a 16-bit address space. It holds the stack pointer and the program counter. A decoder hands it one command at a time: load the pointer, push a 16-bit pair, pop a pair, call a subroutine or return from one. Each 16-bit value is moved as two single-byte accesses over a synchronous single-port byte memory. The stack grows toward lower addresses.

A call and a push use the same write sequence. A call pushes the address of the instruction that follows the three-byte call, then jumps to the target. A return and a pop use the same read sequence, and a return loads the popped value into the program counter. A push can also take its value from the accumulator and flag bytes instead of the operand. The engine is busy while the accesses run. It raises a one-cycle done pulse when a command has finished.

Top module: `stk_engine`

## Requirements
- R1: After reset, sp and pc are 0000h, and busy, done and mem_we are all 0.
- R2: LDSP (cmd_op=5) loads sp from cmd_data. done pulses in the next cycle and no memory write occurs. While the engine is idle and no command is presented, sp holds its value.
- R3: PUSH (cmd_op=1) takes two write cycles right after acceptance. The first writes cmd_data[15:8] at sp-1, the second writes cmd_data[7:0] at sp-2, and sp ends at sp-2.
- R4: POP (cmd_op=2) reads at sp and then at sp+1. pop_data becomes {byte at sp+1, byte at sp} and sp ends at sp+2. done is high in the fourth cycle after acceptance.
- R5: With cmd_psw=1, PUSH stores the pair {cmd_acc, cmd_flags}, so the accumulator goes at the higher address.
- R6: CALL (cmd_op=3) pushes pc+3 (high byte first, at sp-1) and then sets pc to cmd_data.
- R7: RET (cmd_op=4) pops two bytes as in R4 and loads them into pc. pop_data shows the same value.
- R8: Stack-pointer arithmetic wraps modulo 65536. There is no overflow or underflow indication.
- R9: A command presented while busy is 1 is ignored. Codes 0, 6 and 7 do nothing.
- R10: busy is 1 from the cycle after acceptance through the last memory access. done is a single-cycle pulse in the cycle after the last access, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_psw | input | 1 | Push the accumulator/flag pair instead of cmd_data |
| cmd_data | input | 16 | Pair value, call target or new stack pointer |
| cmd_acc | input | 8 | Accumulator byte for a flag-pair push |
| cmd_flags | input | 8 | Flag byte for a flag-pair push |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, one cycle after its address |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished (one-cycle pulse) |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| pop_data | output | 16 | Last popped pair |

## Verification
If the stack pointer is stepped wrongly, the fault shows on mem_addr during the very next access. It also shows on sp when the command completes. A byte-order or capture fault cannot be seen at the write. It shows only when the pair is popped back, on pop_data or pc, some commands later. The bench therefore keeps a byte-level model of the memory and compares every pop and every return against it. A sequencing fault shows up as a wrong busy/done cycle count, which the directed cases measure cycle by cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int CALL_LEN = 3;
  localparam int PAIR_W   = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_LDSP = 3'd5
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_FIN
  } stk_state_e;

  function automatic logic [ADDR_W-1:0] ptr_down(input logic [ADDR_W-1:0] p);
    return p - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_up(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] next_instr(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(CALL_LEN);
  endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output stk_state_e state,
  output logic       ev_accept,
  output logic       ev_ldsp,
  output logic       ev_sp_dn,
  output logic       ev_sp_up,
  output logic       ev_cap_lo,
  output logic       ev_push_fin,
  output logic       ev_pop_fin,
  output logic       is_call_q,
  output logic       is_ret_q,
  output logic       done
);
  logic op_known;
  logic op_wr;
  logic op_rd;

  always_comb begin
    op_wr    = (cmd_op == OP_PUSH) || (cmd_op == OP_CALL);
    op_rd    = (cmd_op == OP_POP)  || (cmd_op == OP_RET);
    op_known = op_wr || op_rd || (cmd_op == OP_LDSP);
    ev_accept   = cmd_valid && (state == ST_IDLE) && op_known;
    ev_ldsp     = ev_accept && (cmd_op == OP_LDSP);
    ev_sp_dn    = (ev_accept && op_wr) || (state == ST_WR_HI);
    ev_sp_up    = (state == ST_RD_LO) || (state == ST_RD_HI);
    ev_cap_lo   = (state == ST_RD_HI);
    ev_push_fin = (state == ST_WR_LO);
    ev_pop_fin  = (state == ST_RD_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_call_q <= 1'b0;
      is_ret_q  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= ev_ldsp || ev_push_fin || ev_pop_fin;
      if (ev_accept) begin
        is_call_q <= (cmd_op == OP_CALL);
        is_ret_q  <= (cmd_op == OP_RET);
      end
      case (state)
        ST_IDLE: begin
          if (ev_accept && op_wr)      state <= ST_WR_HI;
          else if (ev_accept && op_rd) state <= ST_RD_LO;
        end
        ST_WR_HI:  state <= ST_WR_LO;
        ST_WR_LO:  state <= ST_IDLE;
        ST_RD_LO:  state <= ST_RD_HI;
        ST_RD_HI:  state <= ST_RD_FIN;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_SP = '0,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_psw,
  input  logic [PAIR_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] cmd_acc,
  input  logic [BYTE_W-1:0] cmd_flags,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              ev_accept,
  input  logic              ev_ldsp,
  input  logic              ev_sp_dn,
  input  logic              ev_sp_up,
  input  logic              ev_cap_lo,
  input  logic              ev_push_fin,
  input  logic              ev_pop_fin,
  input  logic              is_call_q,
  input  logic              is_ret_q,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] pc,
  output logic [PAIR_W-1:0] wval,
  output logic [PAIR_W-1:0] pop_data
);
  logic [ADDR_W-1:0] target_q;
  logic [BYTE_W-1:0] lo_q;
  logic [PAIR_W-1:0] popped;

  assign popped = {mem_rdata, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= RESET_SP;
      pc       <= RESET_PC;
      wval     <= '0;
      target_q <= '0;
      lo_q     <= '0;
      pop_data <= '0;
    end else begin
      if (ev_accept) begin
        target_q <= cmd_data;
        if (cmd_op == OP_CALL) wval <= next_instr(pc);
        else if (cmd_psw)      wval <= {cmd_acc, cmd_flags};
        else                   wval <= cmd_data;
      end
      if (ev_ldsp)       sp <= cmd_data;
      else if (ev_sp_dn) sp <= ptr_down(sp);
      else if (ev_sp_up) sp <= ptr_up(sp);
      if (ev_cap_lo) lo_q <= mem_rdata;
      if (ev_pop_fin) pop_data <= popped;
      if (ev_push_fin && is_call_q)     pc <= target_q;
      else if (ev_pop_fin && is_ret_q)  pc <= popped;
    end
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_SP = '0,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_psw,
  input  logic [PAIR_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] cmd_acc,
  input  logic [BYTE_W-1:0] cmd_flags,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] pc,
  output logic [PAIR_W-1:0] pop_data
);
  stk_state_e        state;
  logic              ev_accept, ev_ldsp, ev_sp_dn, ev_sp_up, ev_cap_lo;
  logic              ev_push_fin, ev_pop_fin, is_call_q, is_ret_q;
  logic [PAIR_W-1:0] wval;

  stk_seq seq_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .state(state), .ev_accept(ev_accept), .ev_ldsp(ev_ldsp),
    .ev_sp_dn(ev_sp_dn), .ev_sp_up(ev_sp_up), .ev_cap_lo(ev_cap_lo),
    .ev_push_fin(ev_push_fin), .ev_pop_fin(ev_pop_fin),
    .is_call_q(is_call_q), .is_ret_q(is_ret_q), .done(done)
  );

  stk_regs #(.RESET_SP(RESET_SP), .RESET_PC(RESET_PC)) regs_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_psw(cmd_psw),
    .cmd_data(cmd_data), .cmd_acc(cmd_acc), .cmd_flags(cmd_flags),
    .mem_rdata(mem_rdata), .ev_accept(ev_accept), .ev_ldsp(ev_ldsp),
    .ev_sp_dn(ev_sp_dn), .ev_sp_up(ev_sp_up), .ev_cap_lo(ev_cap_lo),
    .ev_push_fin(ev_push_fin), .ev_pop_fin(ev_pop_fin),
    .is_call_q(is_call_q), .is_ret_q(is_ret_q),
    .sp(sp), .pc(pc), .wval(wval), .pop_data(pop_data)
  );

  assign busy      = (state != ST_IDLE);
  assign mem_addr  = sp;
  assign mem_we    = (state == ST_WR_HI) || (state == ST_WR_LO);
  assign mem_wdata = (state == ST_WR_HI) ? wval[PAIR_W-1:BYTE_W] : wval[BYTE_W-1:0];
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] sp,
  input logic        ev_pop_fin
);
  assert_push_descend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == $past(mem_addr) - 16'd1));

  assert_write_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_push_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1) |=> busy);

  assert_idle_sp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(sp));

  // R4 / R8: two wrapping increments across a pair read
  assert_pop_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_fin |-> sp == $past(sp, 2) + 16'd2);
endmodule

bind stk_engine stk_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
  .sp(sp), .ev_pop_fin(ev_pop_fin)
);

// File: tb/stk_engine_tb_top.sv
module stk_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic        cmd_psw = 1'b0;
  logic [15:0] cmd_data = 16'd0;
  logic [7:0]  cmd_acc = 8'd0;
  logic [7:0]  cmd_flags = 8'd0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] sp, pc, pop_data;

  int errors = 0;
  int checks = 0;

  logic [7:0]  mem [256];
  logic [7:0]  mm  [256];
  logic [15:0] m_sp = 16'd0;
  logic [15:0] m_pc = 16'd0;

  always #5ns clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  stk_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_psw(cmd_psw), .cmd_data(cmd_data), .cmd_acc(cmd_acc),
    .cmd_flags(cmd_flags), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .sp(sp), .pc(pc), .pop_data(pop_data)
  );

  function automatic logic [15:0] exp_ret(input logic [15:0] p);
    return 16'(p + 16'd3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [15:0] v);
    m_sp = m_sp - 16'd1; mm[m_sp[7:0]] = v[15:8];
    m_sp = m_sp - 16'd1; mm[m_sp[7:0]] = v[7:0];
  endtask

  task automatic m_pop(output logic [15:0] v);
    v[7:0]  = mm[m_sp[7:0]]; m_sp = m_sp + 16'd1;
    v[15:8] = mm[m_sp[7:0]]; m_sp = m_sp + 16'd1;
  endtask

  // present command at a negedge, release after the accepting edge
  task automatic issue(input logic [2:0] op, input logic [15:0] d, input bit psw,
                       input logic [7:0] a, input logic [7:0] f);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_psw = psw; cmd_acc = a; cmd_flags = f;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_psw = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int exp_cyc);
    int n = 1;
    for (int i = 0; i < 8; i++) begin
      if (done) break;
      @(negedge clk); n++;
    end
    chk(done === 1'b1 && n == exp_cyc, tag, 32'(n), 32'(exp_cyc));
  endtask

  // model-checked command
  task automatic do_op(input logic [2:0] op, input logic [15:0] d, input bit psw,
                       input logic [7:0] a, input logic [7:0] f);
    logic [15:0] v;
    v = 16'd0;
    issue(op, d, psw, a, f);
    case (op)
      3'd1: begin m_push(psw ? {a, f} : d); wait_done("R3 push cycles", 3); end
      3'd2: begin m_pop(v); wait_done("R4 pop cycles", 4);
                  chk(pop_data === v, "R4 pop data", 32'(pop_data), 32'(v)); end
      3'd3: begin m_push(exp_ret(m_pc)); m_pc = d; wait_done("R6 call cycles", 3); end
      3'd4: begin m_pop(v); m_pc = v; wait_done("R7 ret cycles", 4); end
      3'd5: begin m_sp = d; wait_done("R2 ldsp cycles", 1); end
      default: begin
        chk(busy === 1'b0 && done === 1'b0, "R9 unknown op idle", {busy, done}, 0);
      end
    endcase
    chk(sp === m_sp, "R8 sp model", 32'(sp), 32'(m_sp));
    chk(pc === m_pc, "R7 pc model", 32'(pc), 32'(m_pc));
    @(negedge clk);
    chk(done === 1'b0, "R10 done single pulse", 32'(done), 0);
  endtask

  initial begin
    #2ms;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] s0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; mm[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp === 16'd0 && pc === 16'd0, "R1 sp/pc reset", {sp, pc}, 0);
    chk(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0, "R1 flags reset",
        {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load pointer
    issue(3'd5, 16'h0100, 0, 0, 0); m_sp = 16'h0100;
    chk(done === 1'b1 && mem_we === 1'b0, "R2 ldsp done/no write", {done, mem_we}, 2);
    chk(sp === 16'h0100, "R2 ldsp value", 32'(sp), 32'h0100);
    @(negedge clk);
    chk(done === 1'b0 && sp === 16'h0100, "R2 hold", {done, sp}, {1'b0, 16'h0100});

    // R3 push, cycle by cycle
    issue(3'd1, 16'h12F3, 0, 0, 0); m_push(16'h12F3);
    chk(busy && mem_we && mem_addr === 16'h00FF && mem_wdata === 8'h12, "R3 first write",
        {mem_addr, mem_wdata}, {16'h00FF, 8'h12});
    @(negedge clk);
    chk(busy && mem_we && mem_addr === 16'h00FE && mem_wdata === 8'hF3, "R3 second write",
        {mem_addr, mem_wdata}, {16'h00FE, 8'hF3});
    @(negedge clk);
    chk(done && !busy && !mem_we && sp === 16'h00FE, "R10 push end", {done, busy, sp}, {2'b10, 16'h00FE});
    @(negedge clk);

    // R5 flag-pair push, then pops in reverse
    do_op(3'd1, 16'hDEAD, 1, 8'hA5, 8'h3C);
    do_op(3'd2, 0, 0, 0, 0);
    chk(pop_data === 16'hA53C, "R5 flag pair", 32'(pop_data), 32'hA53C);
    do_op(3'd2, 0, 0, 0, 0);
    chk(pop_data === 16'h12F3, "R4 pair order", 32'(pop_data), 32'h12F3);

    // R6/R7 call and return
    do_op(3'd3, 16'h5000, 0, 0, 0);
    chk(pc === 16'h5000 && mm[8'hFF] === 8'h00 && mm[8'hFE] === 8'h03, "R6 call",
        32'(pc), 32'h5000);
    do_op(3'd4, 0, 0, 0, 0);
    chk(pc === 16'h0003, "R7 return", 32'(pc), 32'h0003);

    // R8 wrap
    do_op(3'd5, 16'h0001, 0, 0, 0);
    do_op(3'd1, 16'hBEEF, 0, 0, 0);
    chk(sp === 16'hFFFF, "R8 wrap down", 32'(sp), 32'hFFFF);
    do_op(3'd2, 0, 0, 0, 0);
    chk(sp === 16'h0001 && pop_data === 16'hBEEF, "R8 wrap up", {sp, pop_data}, {16'h0001, 16'hBEEF});

    // R9 command while busy is ignored
    s0 = sp;
    issue(3'd1, 16'h4411, 0, 0, 0); m_push(16'h4411);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_data = 16'h7777;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(done && sp === 16'(s0 - 16'd2), "R9 ignored while busy", 32'(sp), 32'(16'(s0 - 16'd2)));
    @(negedge clk);
    chk(!busy && sp === m_sp, "R9 no late start", {busy, sp}, {1'b0, m_sp});
    do_op(3'd0, 16'h1234, 0, 0, 0);
    do_op(3'd7, 16'h1234, 0, 0, 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      do_op(op, 16'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule